// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block is the exception-tracking spine of an in-order four-register pipeline: decode, execute, memory and write-back. Each slot carries the instruction's PC, a result word, a valid bit, an exception flag and a cause code. When the decode, execute or memory stage reports a fault for the instruction it holds, the report is only written into the flag and cause of that instruction's next pipeline register. Nothing reacts until the instruction reaches write-back. Because instructions arrive at write-back in program order, the oldest faulting instruction is always the one acted on, and no central arbiter is needed.

At write-back the block commits the instruction, or takes a trap. The trap can come from the instruction's own exception flag or from an external interrupt request sampled against that instruction. When a trap is taken, the block does four things in the same cycle. It suppresses the architectural write, kills every younger slot, presents the handler vector as the new fetch address, and latches the trapping PC and its cause.

A two-state controller gates new instructions into decode:
- RUN is the normal state. It moves to SETTLE on the cycle a trap is taken.
- SETTLE always returns to RUN after one cycle.

The instruction offered on the trap cycle is dropped, and so is the one offered during SETTLE. These two slots cover the fetch slots still on the wrong path while the redirect takes effect.

Top module: `pexc_unit`

## Requirements
- R1: After reset no write is committed and no trap is signalled, and the latched trap PC and cause read zero.
- R2: An instruction offered on `in_valid` in cycle n reaches write-back in cycle n+4. A fault raised against it in decode (cycle n+1), execute (n+2) or memory (n+3) produces `trap_take` only in cycle n+4, never earlier.
- R3: When faults for several instructions are raised in the same cycle or in overlapping cycles, the trap is taken for the oldest faulting instruction, and its PC and cause are the ones latched.
- R4: Once an instruction carries an exception, faults raised against it in later stages are ignored. Its first cause code is kept.
- R5: An instruction that traps, whether by exception or by interrupt, does not assert `wr_en`.
- R6: On a trap, every instruction then in decode, execute or memory is discarded. It never commits, and faults raised against it no longer matter.
- R7: Every instruction older than the trapping one commits, in order, with `wr_pc` and `wr_data` equal to the PC and data it was offered with.
- R8: `irq` is taken only in a cycle when write-back holds a valid instruction. That instruction is not committed, `epc` becomes its PC and `ecause` becomes `IRQ_CAUSE` (default 31). With write-back empty, `irq` has no effect.
- R9: If write-back holds an instruction with an exception while `irq` is high, the exception's cause is latched, not `IRQ_CAUSE`.
- R10: During the trap cycle `handler_pc` equals `HANDLER_VEC` (default 0x0100), and it is zero otherwise. From the next cycle `epc` and `ecause` hold the trapping PC and cause.
- R11: The instructions offered in the trap cycle and in the cycle after it are dropped. An instruction offered two cycles after the trap is accepted and commits four cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered to decode |
| in_pc | input | PC_W | PC of offered instruction |
| in_data | input | DATA_W | Result word carried to write-back |
| dec_fault | input | 1 | Fault against instruction in decode |
| dec_cause | input | CAUSE_W | Cause for decode fault |
| exe_fault | input | 1 | Fault against instruction in execute |
| exe_cause | input | CAUSE_W | Cause for execute fault |
| mem_fault | input | 1 | Fault against instruction in memory |
| mem_cause | input | CAUSE_W | Cause for memory fault |
| irq | input | 1 | External interrupt request |
| wr_en | output | 1 | Architectural write of committing instruction |
| wr_pc | output | PC_W | PC of committing instruction |
| wr_data | output | DATA_W | Result of committing instruction |
| trap_take | output | 1 | Trap taken this cycle; flushes younger slots |
| handler_pc | output | PC_W | Redirect address during trap cycle |
| epc | output | PC_W | Latched trapping PC |
| ecause | output | CAUSE_W | Latched trap cause |

## Verification
The hardest cases to reach from the ports are two kinds of collision. In the first, a memory, an execute and a decode fault land on three different instructions in the same cycle. In the second, an interrupt arrives in exactly the cycle a faulting instruction reaches write-back. The bench assigns each of four back-to-back instructions a first-faulting stage from {none, decode, execute, memory} and sweeps all 256 assignments. It keeps raising faults with fresh causes in every later stage, which makes every same-cycle collision and every repeat fault occur. Separate runs then line an interrupt up against an empty write-back, a clean instruction and a faulting one. Two further runs keep issuing across the trap to observe the two dropped slots.

// File: rtl/pexc_pkg.sv
package pexc_pkg;

    // Number of pipeline registers: decode, execute, memory, write-back.
    localparam int PIPE_DEPTH = 4;
    // Stages that can raise a fault against the instruction they hold.
    localparam int NUM_RAISE  = PIPE_DEPTH - 1;
    localparam int WB_IDX     = PIPE_DEPTH - 1;

    typedef enum logic {
        CS_RUN    = 1'b0,
        CS_SETTLE = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/pexc_stage.sv
module pexc_stage #(
    parameter int PC_W    = 16,
    parameter int DATA_W  = 16,
    parameter int CAUSE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               kill,
    input  logic               i_valid,
    input  logic [PC_W-1:0]    i_pc,
    input  logic [DATA_W-1:0]  i_data,
    input  logic               i_exc,
    input  logic [CAUSE_W-1:0] i_cause,
    input  logic               fault,
    input  logic [CAUSE_W-1:0] fault_cause,
    output logic               o_valid,
    output logic [PC_W-1:0]    o_pc,
    output logic [DATA_W-1:0]  o_data,
    output logic               o_exc,
    output logic [CAUSE_W-1:0] o_cause
);

    logic               nx_exc;
    logic [CAUSE_W-1:0] nx_cause;

    // An existing exception wins over any newly raised fault.
    always_comb begin
        nx_exc   = i_valid & (i_exc | fault);
        nx_cause = i_exc ? i_cause : fault_cause;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_pc    <= '0;
            o_data  <= '0;
            o_exc   <= 1'b0;
            o_cause <= '0;
        end else if (kill) begin
            o_valid <= 1'b0;
            o_exc   <= 1'b0;
        end else begin
            o_valid <= i_valid;
            o_pc    <= i_pc;
            o_data  <= i_data;
            o_exc   <= nx_exc;
            o_cause <= nx_cause;
        end
    end

    // R4
    sticky_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && i_exc && !kill) |=> (o_exc && o_cause == $past(i_cause)));

    // R2
    record_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && !i_exc && fault && !kill) |=>
            (o_valid && o_exc && o_cause == $past(fault_cause)));

    // R6
    kill_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (!o_valid && !o_exc));

endmodule

// File: rtl/pexc_commit.sv
module pexc_commit #(
    parameter int PC_W      = 16,
    parameter int DATA_W    = 16,
    parameter int CAUSE_W   = 5,
    parameter int IRQ_CAUSE = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               w_valid,
    input  logic [PC_W-1:0]    w_pc,
    input  logic [DATA_W-1:0]  w_data,
    input  logic               w_exc,
    input  logic [CAUSE_W-1:0] w_cause,
    input  logic               irq,
    output logic               wr_en,
    output logic [PC_W-1:0]    wr_pc,
    output logic [DATA_W-1:0]  wr_data,
    output logic               take,
    output logic [PC_W-1:0]    epc,
    output logic [CAUSE_W-1:0] ecause
);

    localparam logic [CAUSE_W-1:0] IRQ_CODE = CAUSE_W'(IRQ_CAUSE);

    logic [CAUSE_W-1:0] take_cause;

    // Commit decision: own exception first, then interrupt, else retire.
    always_comb begin
        take       = w_valid & (w_exc | irq);
        take_cause = w_exc ? w_cause : IRQ_CODE;
        wr_en      = w_valid & ~take;
        wr_pc      = w_pc;
        wr_data    = w_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc    <= '0;
            ecause <= '0;
        end else if (take) begin
            epc    <= w_pc;
            ecause <= take_cause;
        end
    end

    // R5
    no_write_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && w_exc) |-> (!wr_en && take));

    // R5
    commit_or_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, take}));

    // R8
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!w_valid && !w_exc) |-> !take);

    // R9
    exc_over_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && w_exc && irq) |=> (ecause == $past(w_cause)));

    // R10
    epc_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (epc == $past(w_pc)));

endmodule

// File: rtl/pexc_ctrl.sv
module pexc_ctrl
    import pexc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic accept
);

    ctl_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CS_RUN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CS_RUN:    if (take) state_nx = CS_SETTLE;
            CS_SETTLE: state_nx = CS_RUN;
        endcase
    end

    // Decode intake is closed on the trap cycle and the settle cycle.
    always_comb begin
        accept = 1'b0;
        unique case (state)
            CS_RUN:    accept = ~take;
            CS_SETTLE: accept = 1'b0;
        endcase
    end

    // R11
    settle_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!accept && state == CS_SETTLE));

    // R11
    settle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_SETTLE) |=> (state == CS_RUN));

endmodule

// File: rtl/pexc_unit.sv
module pexc_unit
    import pexc_pkg::*;
#(
    parameter int PC_W        = 16,
    parameter int DATA_W      = 16,
    parameter int CAUSE_W     = 5,
    parameter int IRQ_CAUSE   = 31,
    parameter int HANDLER_VEC = 'h0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [PC_W-1:0]    in_pc,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               dec_fault,
    input  logic [CAUSE_W-1:0] dec_cause,
    input  logic               exe_fault,
    input  logic [CAUSE_W-1:0] exe_cause,
    input  logic               mem_fault,
    input  logic [CAUSE_W-1:0] mem_cause,
    input  logic               irq,
    output logic               wr_en,
    output logic [PC_W-1:0]    wr_pc,
    output logic [DATA_W-1:0]  wr_data,
    output logic               trap_take,
    output logic [PC_W-1:0]    handler_pc,
    output logic [PC_W-1:0]    epc,
    output logic [CAUSE_W-1:0] ecause
);

    localparam logic [PC_W-1:0] VEC = PC_W'(HANDLER_VEC);

    logic [PIPE_DEPTH-1:0] vld;
    logic [PIPE_DEPTH-1:0] exc;
    logic [PC_W-1:0]       st_pc    [PIPE_DEPTH];
    logic [DATA_W-1:0]     st_data  [PIPE_DEPTH];
    logic [CAUSE_W-1:0]    st_cause [PIPE_DEPTH];

    logic [NUM_RAISE-1:0]  raise;
    logic [CAUSE_W-1:0]    raise_cause [NUM_RAISE];

    logic take;
    logic accept;

    // Fault raised against the content of register k loads register k+1.
    assign raise          = {mem_fault, exe_fault, dec_fault};
    assign raise_cause[0] = dec_cause;
    assign raise_cause[1] = exe_cause;
    assign raise_cause[2] = mem_cause;

    for (genvar k = 0; k < PIPE_DEPTH; k++) begin : g_stg
        logic               src_v;
        logic [PC_W-1:0]    src_pc;
        logic [DATA_W-1:0]  src_data;
        logic               src_exc;
        logic [CAUSE_W-1:0] src_cause;
        logic               flt;
        logic [CAUSE_W-1:0] flt_cause;

        if (k == 0) begin : g_head
            assign src_v     = in_valid & accept;
            assign src_pc    = in_pc;
            assign src_data  = in_data;
            assign src_exc   = 1'b0;
            assign src_cause = '0;
            assign flt       = 1'b0;
            assign flt_cause = '0;
        end else begin : g_body
            assign src_v     = vld[k-1];
            assign src_pc    = st_pc[k-1];
            assign src_data  = st_data[k-1];
            assign src_exc   = exc[k-1];
            assign src_cause = st_cause[k-1];
            assign flt       = raise[k-1];
            assign flt_cause = raise_cause[k-1];
        end

        pexc_stage #(
            .PC_W    (PC_W),
            .DATA_W  (DATA_W),
            .CAUSE_W (CAUSE_W)
        ) u_stage (
            .clk         (clk),
            .rst_n       (rst_n),
            .kill        (take),
            .i_valid     (src_v),
            .i_pc        (src_pc),
            .i_data      (src_data),
            .i_exc       (src_exc),
            .i_cause     (src_cause),
            .fault       (flt),
            .fault_cause (flt_cause),
            .o_valid     (vld[k]),
            .o_pc        (st_pc[k]),
            .o_data      (st_data[k]),
            .o_exc       (exc[k]),
            .o_cause     (st_cause[k])
        );
    end

    pexc_commit #(
        .PC_W      (PC_W),
        .DATA_W    (DATA_W),
        .CAUSE_W   (CAUSE_W),
        .IRQ_CAUSE (IRQ_CAUSE)
    ) u_commit (
        .clk     (clk),
        .rst_n   (rst_n),
        .w_valid (vld[WB_IDX]),
        .w_pc    (st_pc[WB_IDX]),
        .w_data  (st_data[WB_IDX]),
        .w_exc   (exc[WB_IDX]),
        .w_cause (st_cause[WB_IDX]),
        .irq     (irq),
        .wr_en   (wr_en),
        .wr_pc   (wr_pc),
        .wr_data (wr_data),
        .take    (take),
        .epc     (epc),
        .ecause  (ecause)
    );

    pexc_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .accept (accept)
    );

    assign trap_take  = take;
    assign handler_pc = take ? VEC : '0;

    // R6
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (vld == '0));

    // R10
    vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |-> (handler_pc == VEC));

    // R2
    exc_only_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc & ~vld) == '0);

endmodule

// File: tb/sim_pexc_unit.sv
module sim_pexc_unit;

    localparam int PC_W = 16, DATA_W = 16, CAUSE_W = 5;
    localparam int IRQ_C = 31, VEC = 'h0100;
    localparam int NONE = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [PC_W-1:0] in_pc = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic dec_fault = 1'b0, exe_fault = 1'b0, mem_fault = 1'b0, irq = 1'b0;
    logic [CAUSE_W-1:0] dec_cause = '0, exe_cause = '0, mem_cause = '0;
    logic wr_en, trap_take;
    logic [PC_W-1:0] wr_pc, handler_pc, epc;
    logic [DATA_W-1:0] wr_data;
    logic [CAUSE_W-1:0] ecause;

    int checks = 0;
    int errors = 0;
    int plan [8];

    always #10 clk = ~clk;

    pexc_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc), .in_data(in_data),
        .dec_fault(dec_fault), .dec_cause(dec_cause), .exe_fault(exe_fault),
        .exe_cause(exe_cause), .mem_fault(mem_fault), .mem_cause(mem_cause), .irq(irq),
        .wr_en(wr_en), .wr_pc(wr_pc), .wr_data(wr_data), .trap_take(trap_take),
        .handler_pc(handler_pc), .epc(epc), .ecause(ecause)
    );

    function automatic logic [PC_W-1:0] pc_of(input int i);
        return PC_W'(16'h0040 + 4 * i);
    endfunction

    function automatic logic [DATA_W-1:0] data_of(input int i);
        return DATA_W'(16'h5A00 + 7 * i);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; irq = 1'b0;
        dec_fault = 1'b0; exe_fault = 1'b0; mem_fault = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(wr_en == 1'b0, "R1 wr_en after reset", int'(wr_en), 0);
        check(trap_take == 1'b0, "R1 trap after reset", int'(trap_take), 0);
        check(epc == '0 && ecause == '0, "R1 epc/ecause after reset",
              int'({epc, ecause}), 0);
    endtask

    // Runs nissue back-to-back instructions with faults from plan[],
    // an optional one-cycle irq, and checks every cycle's outcome.
    task automatic run_seq(input int nissue, input int irq_at, input string tag);
        int j = NONE, te = NONE, ti = NONE, t, tidx, ecexp;
        for (int i = 0; i < nissue; i++)
            if (j == NONE && plan[i] != 0) j = i;
        if (j != NONE) te = j + 4;
        if (irq_at - 4 >= 0 && irq_at - 4 < nissue) ti = irq_at;
        t = (te <= ti) ? te : ti;
        tidx = t - 4;
        ecexp = (te <= ti) ? plan[j] * 8 + j : IRQ_C;
        do_reset();
        for (int c = 0; c < nissue + 6; c++) begin
            int w, kd, ke, km;
            bit expc;
            in_valid = (c < nissue);
            in_pc = pc_of(c);
            in_data = data_of(c);
            kd = c - 1; ke = c - 2; km = c - 3;
            dec_fault = (kd >= 0 && kd < nissue) && plan[kd] != 0 && plan[kd] <= 1;
            dec_cause = CAUSE_W'(8 + kd);
            exe_fault = (ke >= 0 && ke < nissue) && plan[ke] != 0 && plan[ke] <= 2;
            exe_cause = CAUSE_W'(16 + ke);
            mem_fault = (km >= 0 && km < nissue) && plan[km] != 0 && plan[km] <= 3;
            mem_cause = CAUSE_W'(24 + km);
            irq = (c == irq_at);
            #2;
            w = c - 4;
            expc = (w >= 0 && w < nissue && w != tidx && (w < tidx || w >= t + 2));
            // R7 older commit, R6 younger flushed, R11 dropped slots
            check(wr_en == expc, {tag, " R7 R6 R11 wr_en"}, int'(wr_en), int'(expc));
            if (expc && wr_en) begin
                check(wr_pc == pc_of(w) && wr_data == data_of(w),
                      {tag, " R7 commit pc/data"}, int'(wr_pc), int'(pc_of(w)));
            end
            // R2 R3 R8 trap exactly at the oldest faulting commit
            check(trap_take == (c == t), {tag, " R2 R3 R8 trap_take"},
                  int'(trap_take), int'(c == t));
            if (c == t) begin
                check(wr_en == 1'b0, {tag, " R5 write suppressed"}, int'(wr_en), 0);
                check(handler_pc == PC_W'(VEC), {tag, " R10 handler_pc"},
                      int'(handler_pc), VEC);
            end else begin
                check(handler_pc == '0, {tag, " R10 handler_pc idle"}, int'(handler_pc), 0);
            end
            if (c == t + 1) begin
                check(epc == pc_of(tidx), {tag, " R3 R10 epc"}, int'(epc), int'(pc_of(tidx)));
                // R4 sticky cause, R9 exception over irq
                check(ecause == CAUSE_W'(ecexp), {tag, " R4 R9 ecause"}, int'(ecause), ecexp);
            end
            @(negedge clk);
        end
        in_valid = 1'b0; irq = 1'b0;
        dec_fault = 1'b0; exe_fault = 1'b0; mem_fault = 1'b0;
    endtask

    task automatic clear_plan();
        for (int i = 0; i < 8; i++) plan[i] = 0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Sweep of first-faulting stage (0 none,1 dec,2 exe,3 mem) for four instructions.
        for (int code = 0; code < 256; code++) begin
            clear_plan();
            for (int i = 0; i < 4; i++) plan[i] = (code >> (2 * i)) & 3;
            run_seq(4, -1, "sweep");
        end
        // R8: irq with empty write-back, before and after the stream.
        clear_plan();
        run_seq(3, 2, "irq_empty_early");
        clear_plan();
        run_seq(4, 10, "irq_empty_late");
        // R8 R11: irq on a clean instruction, stream continues across trap.
        clear_plan();
        run_seq(8, 5, "irq_clean");
        // R9: irq coincides with a memory-stage exception at commit.
        clear_plan();
        plan[2] = 3;
        run_seq(4, 6, "irq_vs_exc");
        // R11: exception with the stream continuing across the settle cycle.
        clear_plan();
        plan[1] = 2;
        run_seq(8, -1, "settle");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule